// File: doc/BRIEF.md
# Four-Bank GPIO Output and Direction Register File

This block is the register file for four banks of 32 general-purpose pins each. For every bank it keeps an output word, a direction word and an output-enable word. From the output and direction words it works out the level that each pin presents. Software reaches the block over a simple synchronous register bus made of an address, a write strobe, a read strobe, write data and read data. The pin input and pin output vectors run to the pad ring, and the pads themselves sit outside this block.

The output word can be written in two ways. A full write replaces all 32 bits in one access. A half write changes 16 bits, and a protect mask carried in the upper half of the write data chooses which of those bits move, so software can alter single pins without first reading the word. A pin whose direction bit is 0 is not driven and resolves to 1. For every pin whose resolved level changes, the block raises a one-cycle change pulse. The output-enable word can be read and written but has no effect on the pins. Each bank also has a read-only view of its pin inputs.

The decoder sorts every bus access into one of seven access kinds: `ACC_NONE`, `ACC_HALF_LO`, `ACC_HALF_HI`, `ACC_WORD`, `ACC_INPUT`, `ACC_DIR` and `ACC_OE`, each paired with a bank index. Only one access kind applies in a cycle. There is no sequencing between kinds: each access is decoded and completed in the cycle in which it arrives.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every output, direction and output-enable word is zero, every pin output is 1, no change pulse is high, and the read data is zero.
- R2: The full output word of bank b is at address 0x040 + 4*b. A write there replaces all 32 bits, and a read returns the stored word.
- R3: The half-write registers of bank b are at 0x000 + 8*b for bits [15:0] and at 0x004 + 8*b for bits [31:16]. Write data bits [31:16] form a protect mask: a 1 keeps the old output bit, and a 0 loads the new bit from write data [15:0]. The other half of the word is not changed.
- R4: A read of a half-write register returns the matching half of the output word in bits [15:0] and zero in bits [31:16].
- R5: The input view of bank b at 0x060 + 4*b reads the current pin input levels of that bank. Writes to it change nothing.
- R6: The direction word of bank b is at 0x204 + 0x40*b and the output-enable word is at 0x208 + 0x40*b. Both can be read and written. The output-enable word does not affect any pin output.
- R7: Pin output bit i of a bank equals output word bit i when direction bit i is 1, and equals 1 when direction bit i is 0.
- R8: A change pulse is high for exactly the cycle after the write edge that changed a pin's resolved level, and only for pins whose level changed. A write that leaves the level the same gives no pulse.
- R9: Any address outside the decoded registers, including addresses that are not word aligned, reads as zero, and a write to it changes nothing.
- R10: Read data appears on the cycle after the read strobe and is zero on cycles that follow no read. A read in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 128 | Pin input levels; bank b uses bits [32*b+31:32*b] |
| pin_out | output | 128 | Resolved pin levels, packed the same way as pin_in |
| pin_chg | output | 128 | One-cycle change pulse for each pin |

## Verification
A wrong output or direction bit shows up on `pin_out` half a cycle after the write edge that stored it. It also produces a false or missing bit on `pin_chg` in that same cycle, so a fault in storage or resolution appears at once rather than only on a later readback. A wrong decode shows up in one of three ways: a different bank's pins move, a read returns nonzero from an unmapped address, or the wrong half of a word takes the value. All of these are visible one cycle after the access. A protect-mask fault can only be seen by using masks that mix kept and loaded bits over a word that already holds nonzero data.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

    parameter int NBANK  = 4;
    parameter int BANK_W = 32;
    parameter int ADDR_W = 12;

    localparam int HALF_W = BANK_W / 2;
    localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    localparam int HALF_BASE   = 'h000;
    localparam int HALF_STRIDE = 8;
    localparam int WORD_BASE   = 'h040;
    localparam int INPUT_BASE  = 'h060;
    localparam int WORD_STRIDE = 4;
    localparam int CTRL_BASE   = 'h200;
    localparam int CTRL_STRIDE = 'h40;
    localparam int CTRL_DIR    = 'h04;
    localparam int CTRL_OE     = 'h08;

    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_HALF_LO = 3'd1,
        ACC_HALF_HI = 3'd2,
        ACC_WORD    = 3'd3,
        ACC_INPUT   = 3'd4,
        ACC_DIR     = 3'd5,
        ACC_OE      = 3'd6
    } acc_kind_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [BIDX_W-1:0] bank_idx
);

    always_comb begin
        kind     = ACC_NONE;
        bank_idx = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (addr == ADDR_W'(HALF_BASE + b * HALF_STRIDE)) begin
                kind     = ACC_HALF_LO;
                bank_idx = BIDX_W'(b);
            end
            if (addr == ADDR_W'(HALF_BASE + b * HALF_STRIDE + HALF_STRIDE / 2)) begin
                kind     = ACC_HALF_HI;
                bank_idx = BIDX_W'(b);
            end
            if (addr == ADDR_W'(WORD_BASE + b * WORD_STRIDE)) begin
                kind     = ACC_WORD;
                bank_idx = BIDX_W'(b);
            end
            if (addr == ADDR_W'(INPUT_BASE + b * WORD_STRIDE)) begin
                kind     = ACC_INPUT;
                bank_idx = BIDX_W'(b);
            end
            if (addr == ADDR_W'(CTRL_BASE + b * CTRL_STRIDE + CTRL_DIR)) begin
                kind     = ACC_DIR;
                bank_idx = BIDX_W'(b);
            end
            if (addr == ADDR_W'(CTRL_BASE + b * CTRL_STRIDE + CTRL_OE)) begin
                kind     = ACC_OE;
                bank_idx = BIDX_W'(b);
            end
        end
    end

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
    import gpio_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  acc_kind_e         kind,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] pins_in,
    output logic [BANK_W-1:0] rd_word,
    output logic [BANK_W-1:0] pins_out,
    output logic [BANK_W-1:0] pins_chg
);

    logic [BANK_W-1:0] out_q;
    logic [BANK_W-1:0] dir_q;
    logic [BANK_W-1:0] oe_q;
    logic [BANK_W-1:0] level_q;
    logic [BANK_W-1:0] resolved;
    logic [HALF_W-1:0] keep_mask;
    logic [HALF_W-1:0] new_bits;

    assign keep_mask = wdata[BANK_W-1:HALF_W];
    assign new_bits  = wdata[HALF_W-1:0];

    // Undriven pins resolve high.
    assign resolved = (out_q & dir_q) | ~dir_q;
    assign pins_out = resolved;
    assign pins_chg = resolved ^ level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '0;
            oe_q    <= '0;
            level_q <= '1;
        end else begin
            level_q <= resolved;
            if (wr_en) begin
                unique case (kind)
                    ACC_WORD:    out_q <= wdata;
                    ACC_HALF_LO: out_q[HALF_W-1:0] <=
                        (out_q[HALF_W-1:0] & keep_mask) | (new_bits & ~keep_mask);
                    ACC_HALF_HI: out_q[BANK_W-1:HALF_W] <=
                        (out_q[BANK_W-1:HALF_W] & keep_mask) | (new_bits & ~keep_mask);
                    ACC_DIR:     dir_q <= wdata;
                    ACC_OE:      oe_q  <= wdata;
                    default:     ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (kind)
            ACC_WORD:    rd_word = out_q;
            ACC_HALF_LO: rd_word = BANK_W'(out_q[HALF_W-1:0]);
            ACC_HALF_HI: rd_word = BANK_W'(out_q[BANK_W-1:HALF_W]);
            ACC_INPUT:   rd_word = pins_in;
            ACC_DIR:     rd_word = dir_q;
            ACC_OE:      rd_word = oe_q;
            default:     rd_word = '0;
        endcase
    end

    // R3
    half_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_HALF_LO) |=> $stable(out_q[BANK_W-1:HALF_W]));

    // R3
    half_hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_HALF_HI) |=> $stable(out_q[HALF_W-1:0]));

    // R6
    oe_no_pin_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_OE) |=> $stable(pins_out));

    // R8
    quiet_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (pins_chg == '0));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_regs_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [BANK_W-1:0]       bus_wdata,
    output logic [BANK_W-1:0]       bus_rdata,
    input  logic [NBANK*BANK_W-1:0] pin_in,
    output logic [NBANK*BANK_W-1:0] pin_out,
    output logic [NBANK*BANK_W-1:0] pin_chg
);

    acc_kind_e         kind;
    logic [BIDX_W-1:0] bank_idx;
    logic [BANK_W-1:0] bank_rd [NBANK];
    logic [BANK_W-1:0] rdata_q;

    gpio_addr_decode u_decode (
        .addr     (bus_addr),
        .kind     (kind),
        .bank_idx (bank_idx)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_wr && (kind != ACC_NONE) && (bank_idx == BIDX_W'(b));

        gpio_pin_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .kind     (kind),
            .wdata    (bus_wdata),
            .pins_in  (pin_in[b*BANK_W +: BANK_W]),
            .rd_word  (bank_rd[b]),
            .pins_out (pin_out[b*BANK_W +: BANK_W]),
            .pins_chg (pin_chg[b*BANK_W +: BANK_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd && kind != ACC_NONE) begin
            rdata_q <= bank_rd[bank_idx];
        end else begin
            rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;

    // R10
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && kind == ACC_NONE) |=> $stable(pin_out));

    // R5
    input_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && kind == ACC_INPUT) |=> $stable(pin_out));

    // R8
    no_write_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (pin_chg == '0));

endmodule

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int W  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [11:0]    bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NB*W-1:0] pin_in = '0;
    logic [NB*W-1:0] pin_out;
    logic [NB*W-1:0] pin_chg;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] m_out [NB];
    logic [31:0] m_dir [NB];
    logic [31:0] m_oe  [NB];
    logic [NB*W-1:0] pins_before;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_cap;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_regs i_gpio_bank_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_chg   (pin_chg)
    );

    function automatic logic [NB*W-1:0] model_pins();
        logic [NB*W-1:0] v;
        for (int b = 0; b < NB; b++)
            v[b*W +: W] = (m_out[b] & m_dir[b]) | ~m_dir[b];
        return v;
    endfunction

    function automatic logic [31:0] model_read(logic [11:0] a);
        for (int b = 0; b < NB; b++) begin
            if (a == 12'(8*b))        return {16'h0, m_out[b][15:0]};
            if (a == 12'(8*b + 4))    return {16'h0, m_out[b][31:16]};
            if (a == 12'('h40 + 4*b)) return m_out[b];
            if (a == 12'('h60 + 4*b)) return pin_in[b*W +: W];
            if (a == 12'('h204 + 'h40*b)) return m_dir[b];
            if (a == 12'('h208 + 'h40*b)) return m_oe[b];
        end
        return 32'h0;
    endfunction

    function automatic logic [15:0] merge16(logic [15:0] old, logic [31:0] d);
        return (old & d[31:16]) | (d[15:0] & ~d[31:16]);
    endfunction

    task automatic model_write(logic [11:0] a, logic [31:0] d);
        for (int b = 0; b < NB; b++) begin
            if (a == 12'(8*b))        m_out[b][15:0]  = merge16(m_out[b][15:0], d);
            if (a == 12'(8*b + 4))    m_out[b][31:16] = merge16(m_out[b][31:16], d);
            if (a == 12'('h40 + 4*b)) m_out[b] = d;
            if (a == 12'('h204 + 'h40*b)) m_dir[b] = d;
            if (a == 12'('h208 + 'h40*b)) m_oe[b] = d;
        end
    endtask

    task automatic check(string tag, logic [NB*W-1:0] act, logic [NB*W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        pins_before = model_pins();
        model_write(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check_after_write(string tag);
        check({tag, " pin_out"}, pin_out, model_pins());
        check({tag, " pin_chg"}, pin_chg, pins_before ^ model_pins());
    endtask

    task automatic do_read(logic [11:0] a, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_write_read(logic [11:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        pins_before = model_pins();
        model_write(a, d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    // Monitor: pops expected read data one cycle after each read strobe.
    always @(posedge clk) begin
        rd_cap = bus_rd;
        #1;
        if (rd_cap && rst_n) begin
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R10 unexpected read response actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), {96'h0, bus_rdata}, {96'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_out[b] = '0; m_dir[b] = '0; m_oe[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_out reset", pin_out, {NB*W{1'b1}});
        check("R1 pin_chg reset", pin_chg, '0);
        check("R1 rdata reset", {96'h0, bus_rdata}, '0);
        for (int b = 0; b < NB; b++) begin
            do_read(12'('h40 + 4*b), "R1 word reset");
            do_read(12'('h204 + 'h40*b), "R1 dir reset");
            do_read(12'('h208 + 'h40*b), "R1 oe reset");
        end

        // R2 full word write, dir still 0 so R7 keeps pins high
        do_write(12'h040, 32'hA5A5_5A5A);
        check_after_write("R7 undriven high");
        do_read(12'h040, "R2 word readback");

        // R6 / R7 direction drives upper half
        do_write(12'h204, 32'hFFFF_0000);
        check_after_write("R7 dir resolve");
        do_read(12'h204, "R6 dir readback");
        @(negedge clk);
        check("R8 pulse one cycle", pin_chg, '0);

        // R8 same value again: no pulse
        do_write(12'h040, 32'hA5A5_5A5A);
        check_after_write("R8 no change no pulse");

        // R3 half writes on bank 1, fully driven
        do_write(12'h244, 32'hFFFF_FFFF);
        check_after_write("R7 bank1 drive");
        do_write(12'h044, 32'h0F0F_F0F0);
        check_after_write("R2 bank1 word");
        do_write(12'h008, 32'h00FF_1234);
        check_after_write("R3 half lo masked");
        do_write(12'h00C, 32'hF000_BEEF);
        check_after_write("R3 half hi masked");
        do_write(12'h00C, 32'h0000_0000);
        check_after_write("R3 half hi clear");
        do_read(12'h008, "R4 half lo read");
        do_read(12'h00C, "R4 half hi read");
        do_read(12'h044, "R3 word after halves");

        // R5 input view
        pin_in = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        for (int b = 0; b < NB; b++)
            do_read(12'('h60 + 4*b), "R5 input read");
        do_write(12'h064, 32'hDEAD_BEEF);
        check_after_write("R5 input write ignored");
        do_read(12'h064, "R5 input after write");
        do_read(12'h044, "R5 word after input write");

        // R6 output enable has no pin effect
        do_write(12'h288, 32'h1234_5678);
        check_after_write("R6 oe no pin effect");
        do_read(12'h288, "R6 oe readback");

        // R9 unmapped accesses
        do_write(12'h020, 32'hFFFF_FFFF);
        check_after_write("R9 unmapped write");
        do_write(12'h041, 32'h0000_0000);
        check_after_write("R9 unaligned write");
        do_read(12'h020, "R9 unmapped read");
        do_read(12'h200, "R9 ctrl gap read");
        do_read(12'hFFC, "R9 top read");
        do_read(12'h041, "R9 unaligned read");
        do_read(12'h040, "R9 word intact");

        // R10 read and write in one cycle returns old value
        do_write_read(12'h04C, 32'hCAFE_F00D, "R10 write-read old value");
        check_after_write("R10 pins after write-read");
        do_read(12'h04C, "R10 new value");
        @(negedge clk);
        check("R10 rdata idle zero", {96'h0, bus_rdata}, '0);

        // R7 bank 3 mixed direction
        do_write(12'h2C4, 32'h0000_FFFF);
        check_after_write("R7 bank3 partial dir");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_vec++; n_bad++;
            $display("FAIL R10 missing responses actual=%0d expected=0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule